// File: doc/BRIEF.md
# 3x3 Neighbourhood Filter Stage

This stage sits in a raster-scan pixel pipeline. It accepts one pixel per cycle, keeps the two previous image rows in circularly addressed row memories, and assembles a 3x3 neighbourhood in a small register array. Each step shifts one new column of three vertically adjacent pixels into that array. The column is made of two values read from the row memories plus the incoming pixel. A weighted sum over the nine registered taps, with signed coefficients, is shifted right and clipped to the pixel range. The result is registered and then queued for the consumer.

Both the input and the output use a valid/ready handshake, and each side has a small elastic queue. A stall on either side pauses the stage without disturbing the window. A frame begins with the pixel that carries the start-of-frame flag, and its size comes from the width and height configuration inputs. Each output pixel reports the result for the window centre, which lags the input by one row plus one pixel. Output pixels carry a start-of-frame flag and an end-of-row flag. Neighbours that fall outside the image are replaced by the nearest pixel inside it. After the last input row, the stage produces the final output row on its own, without further input.

Top module: `stencil_window`

## Requirements
- R1: While reset is held and after its release with no input, out_valid is 0 and in_ready is 1.
- R2: Each output equals sat((sum over r,c of w[r*3+c] * P(x+c-1, y+r-1)) >>> cfg_shift). Row r=0 is the row above and column c=0 is the column to the left. w[i] is the signed byte cfg_weights[8*i +: 8], and the sum uses arithmetic right shift.
- R3: At column 0 the left neighbours are replaced by the pixels of column 0. At column cfg_width-1 the right neighbours are replaced by the pixels of that column.
- R4: At row 0 the row above is replaced by row 0. At row cfg_height-1 the row below is replaced by that row.
- R5: A frame of cfg_width x cfg_height input pixels yields exactly that many outputs, in raster order. out_sof is 1 only on the output for (0,0), and out_eol is 1 only on outputs at column cfg_width-1. No output appears beyond that count.
- R6: Pixels accepted while no frame is in progress and without in_sof are discarded. A frame starts at the next pixel accepted with in_sof=1.
- R7: A weighted sum below 0 after the shift gives 0. A sum above 255 after the shift gives 255.
- R8: No output of a frame appears before min(cfg_width+1, cfg_width*cfg_height) of its pixels have been accepted.
- R9: Gaps in in_valid and deassertion of out_ready do not change any output value. While out_valid=1 and out_ready=0, the output holds steady, and the output queue never receives data while full.
- R10: With continuous input and out_ready held at 1, the outputs of a frame come on consecutive cycles, from the first output to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 7 | Pixels per row, 1 to MAX_W |
| cfg_height | input | 11 | Rows per frame, 1 to MAX_H |
| cfg_weights | input | 72 | Nine signed 8-bit coefficients, tap i at bits 8*i+7:8*i |
| cfg_shift | input | 4 | Right shift applied to the weighted sum |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Input queue can take a pixel |
| in_pix | input | 8 | Input pixel value |
| in_sof | input | 1 | Input pixel is the first of a frame |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 8 | Filtered pixel |
| out_sof | output | 1 | Output pixel is (0,0) |
| out_eol | output | 1 | Output pixel is the last of its row |

## Verification
If the circular row addressing goes wrong, it shows as wrong values from the second output row on. A wrong column or row counter first appears at the edges, as wrong values or misplaced row flags, within one row of outputs. If the window shift or the coefficient order is wrong, every output of a frame with asymmetric weights is off right away. A mistake in the queue occupancy accounting appears as lost, repeated or extra outputs at the first downstream stall. The sweep runs every small width and height with both kinds of stall, so each of these faults reaches the ports within a few frames.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
    localparam int TAPS     = 3;
    localparam int NTAP     = TAPS * TAPS;
    localparam int PIX_W    = 8;
    localparam int COEF_W   = 8;
endpackage

// File: rtl/stencil_fifo.sv
module stencil_fifo #(
    parameter int DW    = 9,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          full,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t         s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign dout    = mem_q[s_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        if (do_pop)  s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (!do_push && do_pop) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= din;
    end
endmodule

// File: rtl/stencil_rowstore.sv
module stencil_rowstore #(
    parameter int PW    = 8,
    parameter int MAX_W = 64,
    parameter int LINES = 2
) (
    input  logic                        clk,
    input  logic [$clog2(MAX_W)-1:0]    addr,
    input  logic                        we,
    input  logic [PW-1:0]               din,
    output logic [LINES-1:0][PW-1:0]    rd
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [PW-1:0] mem_q [MAX_W];
        assign rd[g] = mem_q[addr];
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (we) mem_q[addr] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (we) mem_q[addr] <= rd[g-1];
            end
        end
    end
endmodule

// File: rtl/stencil_mac.sv
module stencil_mac
    import stencil_pkg::*;
#(
    parameter int PW  = 8,
    parameter int CW  = 8,
    parameter int SHW = 4
) (
    input  logic [NTAP-1:0][PW-1:0] taps,
    input  logic [NTAP*CW-1:0]      coefs,
    input  logic [SHW-1:0]          shift,
    output logic [PW-1:0]           pix
);
    localparam int ACC_W = PW + CW + 5;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PW) - 1);

    logic signed [ACC_W-1:0] acc, term_a, term_b, scaled;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            term_a = ACC_W'($signed({1'b0, taps[i]}));
            term_b = ACC_W'($signed(coefs[i*CW +: CW]));
            acc    = acc + term_a * term_b;
        end
        scaled = acc >>> shift;
        if (scaled < 0)         pix = '0;
        else if (scaled > MAXV) pix = MAXV[PW-1:0];
        else                    pix = scaled[PW-1:0];
    end
endmodule

// File: rtl/stencil_window.sv
module stencil_window
    import stencil_pkg::*;
#(
    parameter int MAX_W     = 64,
    parameter int MAX_H     = 1024,
    parameter int PW        = PIX_W,
    parameter int CW        = COEF_W,
    parameter int SHW       = 4,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 4,
    localparam int XW       = $clog2(MAX_W),
    localparam int YW       = $clog2(MAX_H + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XW:0]        cfg_width,
    input  logic [YW-1:0]      cfg_height,
    input  logic [NTAP*CW-1:0] cfg_weights,
    input  logic [SHW-1:0]     cfg_shift,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PW-1:0]      in_pix,
    input  logic               in_sof,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PW-1:0]      out_pix,
    output logic               out_sof,
    output logic               out_eol
);
    localparam int OCW = $clog2(OUT_DEPTH + 1);

    typedef struct packed {
        logic                    run;
        logic [XW-1:0]           xi;
        logic [YW-1:0]           yi;
        logic [XW-1:0]           ox;
        logic [YW-1:0]           oy;
        logic [NTAP-1:0][PW-1:0] win;
        logic                    win_vld;
        logic [PW+1:0]           res;
        logic                    res_vld;
        logic [OCW-1:0]          ocnt;
    } core_t;

    core_t                   s_d, s_q;
    logic                    ififo_full, ififo_empty, in_pop;
    logic [PW:0]             ififo_dout;
    logic                    ofifo_push, ofifo_full, ofifo_empty, opop;
    logic [1:0][PW-1:0]      lb_rd;
    logic                    lb_we;
    logic [NTAP-1:0][PW-1:0] taps;
    logic [PW-1:0]           mac_pix;
    logic [2:0][PW-1:0]      col;
    logic [XW-1:0]           wlast;
    logic [YW-1:0]           hend, hlast;
    logic                    drain, room, step;

    assign in_ready   = !ififo_full;
    assign out_valid  = !ofifo_empty;
    assign opop       = out_valid && out_ready;
    assign ofifo_push = s_q.res_vld;
    assign wlast      = XW'(cfg_width - 1'b1);
    assign hend       = YW'(cfg_height + 1'b1);
    assign hlast      = YW'(cfg_height - 1'b1);

    stencil_fifo #(.DW(PW + 1), .DEPTH(IN_DEPTH)) u_ififo (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .din({in_sof, in_pix}),
        .full(ififo_full), .pop(in_pop), .dout(ififo_dout), .empty(ififo_empty)
    );

    stencil_rowstore #(.PW(PW), .MAX_W(MAX_W), .LINES(2)) u_rows (
        .clk(clk), .addr(s_q.xi), .we(lb_we), .din(ififo_dout[PW-1:0]), .rd(lb_rd)
    );

    stencil_mac #(.PW(PW), .CW(CW), .SHW(SHW)) u_mac (
        .taps(taps), .coefs(cfg_weights), .shift(cfg_shift), .pix(mac_pix)
    );

    stencil_fifo #(.DW(PW + 2), .DEPTH(OUT_DEPTH)) u_ofifo (
        .clk(clk), .rst_n(rst_n), .push(ofifo_push), .din(s_q.res),
        .full(ofifo_full), .pop(opop), .dout({out_sof, out_eol, out_pix}), .empty(ofifo_empty)
    );

    // column clamp: edge columns reuse the centre column of the window
    always_comb begin
        for (int r = 0; r < TAPS; r++) begin
            taps[r*TAPS + 1] = s_q.win[r*TAPS + 1];
            taps[r*TAPS + 0] = (s_q.ox == '0)   ? s_q.win[r*TAPS + 1] : s_q.win[r*TAPS + 0];
            taps[r*TAPS + 2] = (s_q.ox == wlast) ? s_q.win[r*TAPS + 1] : s_q.win[r*TAPS + 2];
        end
    end

    always_comb begin
        s_d    = s_q;
        in_pop = 1'b0;
        lb_we  = 1'b0;
        step   = 1'b0;
        drain  = (s_q.yi >= cfg_height);
        room   = (32'(s_q.ocnt) + 32'(s_q.win_vld) + 32'(s_q.res_vld)) < 32'(OUT_DEPTH);

        // row clamp applied as the column enters the window
        col[1] = lb_rd[0];
        col[0] = (s_q.yi == YW'(1)) ? lb_rd[0] : lb_rd[1];
        col[2] = drain ? lb_rd[0] : ififo_dout[PW-1:0];

        if (!s_q.run) begin
            if (!ififo_empty) begin
                if (ififo_dout[PW]) s_d.run = 1'b1;
                else                in_pop  = 1'b1;
            end
        end else if ((drain || !ififo_empty) && room) begin
            step = 1'b1;
        end

        s_d.win_vld = 1'b0;
        if (step) begin
            for (int r = 0; r < TAPS; r++) begin
                s_d.win[r*TAPS + 0] = s_q.win[r*TAPS + 1];
                s_d.win[r*TAPS + 1] = s_q.win[r*TAPS + 2];
                s_d.win[r*TAPS + 2] = col[r];
            end
            in_pop      = !drain;
            lb_we       = !drain;
            s_d.win_vld = (s_q.yi >= YW'(2)) || ((s_q.yi == YW'(1)) && (s_q.xi != '0));
            if (s_q.yi == hend) begin
                s_d.run = 1'b0;
                s_d.xi  = '0;
                s_d.yi  = '0;
            end else if (s_q.xi == wlast) begin
                s_d.xi = '0;
                s_d.yi = s_q.yi + 1'b1;
            end else begin
                s_d.xi = s_q.xi + 1'b1;
            end
        end

        s_d.res_vld = s_q.win_vld;
        if (s_q.win_vld) begin
            s_d.res = {(s_q.ox == '0) && (s_q.oy == '0), s_q.ox == wlast, mac_pix};
            if (s_q.ox == wlast) begin
                s_d.ox = '0;
                s_d.oy = (s_q.oy == hlast) ? '0 : s_q.oy + 1'b1;
            end else begin
                s_d.ox = s_q.ox + 1'b1;
            end
        end

        if (s_q.res_vld && !opop)      s_d.ocnt = s_q.ocnt + 1'b1;
        else if (!s_q.res_vld && opop) s_d.ocnt = s_q.ocnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/stencil_window_chk.sv
module stencil_window_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_pix,
    input logic          out_sof,
    input logic          out_eol,
    input logic          ofifo_push,
    input logic          ofifo_full
);
    logic [31:0] n_in_q, n_out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_in_q  <= '0;
            n_out_q <= '0;
        end else begin
            if (in_valid && in_ready)   n_in_q  <= n_in_q + 1'b1;
            if (out_valid && out_ready) n_out_q <= n_out_q + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_push |-> !ofifo_full);

    assert_out_le_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        n_out_q <= n_in_q);
endmodule

bind stencil_window stencil_window_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol), .ofifo_push(ofifo_push), .ofifo_full(ofifo_full)
);

// File: tb/stencil_window_tb.sv
module stencil_window_tb;
    localparam int CLK_NS = 10;
    localparam int MAX_W  = 64;
    localparam int MAX_H  = 1024;
    localparam int XW     = $clog2(MAX_W);
    localparam int YW     = $clog2(MAX_H + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [XW:0]   cfg_width = '0;
    logic [YW-1:0] cfg_height = '0;
    logic [71:0]   cfg_weights = '0;
    logic [3:0]    cfg_shift = '0;
    logic          in_valid = 1'b0, in_ready, in_sof = 1'b0;
    logic [7:0]    in_pix = '0;
    logic          out_valid, out_ready = 1'b1, out_sof, out_eol;
    logic [7:0]    out_pix;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 1'b0;
    int img [0:255];
    int wt  [0:8];
    int sh;
    int nacc;

    stencil_window #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_weights(cfg_weights), .cfg_shift(cfg_shift),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int raw_at(input int x, input int y, input int w, input int h);
        int s = 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                s += wt[r*3+c] * img[clampi(y+r-1, 0, h-1)*w + clampi(x+c-1, 0, w-1)];
        return s >>> sh;
    endfunction

    task automatic set_kernel(input int k);
        int sets [5][9] = '{
            '{0, 0, 0, 0, 1, 0, 0, 0, 0},
            '{1, 1, 1, 1, 1, 1, 1, 1, 1},
            '{-1, -1, -1, -1, 8, -1, -1, -1, -1},
            '{1, 2, 3, 4, 5, 6, 7, 8, 9},
            '{3, -2, 1, 0, 5, -1, 2, 4, -3}};
        int shs [5] = '{0, 3, 0, 6, 3};
        for (int i = 0; i < 9; i++) begin
            wt[i] = sets[k][i];
            cfg_weights[8*i +: 8] = 8'(sets[k][i]);
        end
        sh = shs[k];
        cfg_shift = 4'(sh);
    endtask

    task automatic producer(input int n, input int junk, input int smode);
        int idx = -junk;
        while (idx < n) begin
            @(negedge clk);
            if (smode == 2 && (cyc % 3) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_pix   = (idx < 0) ? 8'(77 + idx) : 8'(img[idx]);
                in_sof   = (idx == 0);
                if (in_ready) begin
                    if (idx >= 0) nacc++;
                    idx++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic consumer(input int w, input int h, input int smode, input int junk);
        int n = w * h, nout = 0, t = 0, first_c = -1, last_c = 0, ferr = errors;
        int need = (w + 1 < n) ? w + 1 : n;
        while (nout < n && t < 5000) begin
            @(negedge clk);
            t++;
            out_ready = (smode == 0) ? 1'b1 : ((cyc % 4) != 1);
            if (out_valid && out_ready) begin
                int x = nout % w, y = nout / w, raw, ev;
                string tag;
                if (first_c < 0) begin
                    first_c = cyc;
                    check(nacc >= need, "R8", "inputs accepted before first output", nacc, need);
                end
                raw = raw_at(x, y, w, h);
                ev  = clampi(raw, 0, 255);
                if (raw != ev) tag = "R7";
                else if (x == 0 || x == w-1) tag = "R3";
                else if (y == 0 || y == h-1) tag = "R4";
                else tag = "R2";
                check(out_pix == 8'(ev), tag, $sformatf("pixel (%0d,%0d) %0dx%0d", x, y, w, h), out_pix, ev);
                check(out_sof == (nout == 0), "R5", "out_sof", out_sof, nout == 0);
                check(out_eol == (x == w-1), "R5", "out_eol", out_eol, x == w-1);
                last_c = cyc;
                nout++;
            end
        end
        check(nout == n, (junk > 0) ? "R6" : "R5", "output count", nout, n);
        if (smode == 0)
            check(last_c - first_c == n - 1, "R10", "cycles first to last output", last_c - first_c, n - 1);
        else
            check(errors == ferr, "R9", "errors in stalled frame", errors - ferr, 0);
        out_ready = 1'b1;
    endtask

    task automatic run_frame(input int w, input int h, input int k, input int ptn, input int smode, input int junk, input int f);
        cfg_width  = (XW+1)'(w);
        cfg_height = YW'(h);
        set_kernel(k);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                img[y*w+x] = (ptn == 0) ? ((x*53 + y*101 + f*29 + ((x*y) % 7) * 17) % 256)
                           : (ptn == 1) ? (((x + y) % 2) ? 255 : 0) : 255;
        nacc = 0;
        fork
            producer(w * h, junk, smode);
            consumer(w, h, smode, junk);
        join
        repeat (8) @(negedge clk);
        check(!out_valid, "R5", "no extra output after frame", out_valid, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ws [5] = '{1, 2, 3, 4, 7};
        int hs [4] = '{1, 2, 3, 5};
        int f = 0;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready, "R1", "in_ready after reset", in_ready, 1);
        for (int wi = 0; wi < 5; wi++)
            for (int hi = 0; hi < 4; hi++) begin
                run_frame(ws[wi], hs[hi], (wi + hi) % 5, 0, (wi + 2*hi) % 3, ((wi + hi) % 2) * 2, f);
                f++;
            end
        run_frame(6, 4, 2, 1, 0, 0, f++);
        run_frame(5, 3, 1, 2, 1, 1, f++);
        run_frame(MAX_W, 2, 4, 0, 1, 0, f++);
        run_frame(MAX_W, 3, 3, 0, 0, 2, f++);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule